// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home side of a directory-based coherence scheme for a shared-memory machine with a fixed set of nodes. It owns a slice of physical memory and, for every block in that slice, a directory record. Each record holds a sharing state, a bit per node telling which caches hold a copy, and the identity of the node that owns a modified copy. The states are Uncached (no cache holds the block), Shared (one or more clean copies) and Exclusive (a single cache has written the block, so memory is stale). Because the address space is split statically between nodes, every request reaching this block is for a block that lives here.

Caches send read misses, write misses and write-backs on the request port. The controller answers a miss with a data reply to the requester. When other copies are in the way, it first sends point-to-point invalidates to the recorded sharers. When a block is held modified, it first sends a fetch to the owner and waits on the response port for that owner's data. It works on one miss at a time and lowers its ready signal until the reply has gone out. Memory is a small register array that resets to zero.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with no sharers and reads as zero. `req_ready` is 1 and `msg_valid` is 0.
- R2: A read miss (`req_type` 0) to an Uncached or Shared block produces exactly one message, a data reply (`msg_type` 0) to the requester carrying the memory value. The requester is added to the sharers and the block becomes Shared.
- R3: A write miss (`req_type` 1) to a Shared block sends an invalidate (`msg_type` 1) to each sharer other than the requester, one per cycle in ascending node number, and then a data reply. Afterwards the requester is the only holder and the owner, and the block is Exclusive.
- R4: A write miss to an Uncached block is answered directly with a data reply, and the block becomes Exclusive with the requester as owner.
- R5: A read miss to an Exclusive block sends a fetch (`msg_type` 2) to the owner and waits for its response. It writes the response data to memory and replies with that data. The block becomes Shared with the old owner and the requester as sharers.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate (`msg_type` 3) to the owner and waits for its response. It writes that data to memory, replies with it, and makes the requester the new exclusive owner.
- R7: While waiting for a fetch response, a response from any node other than the owner is ignored: no reply is sent and memory is not changed.
- R8: A write-back (`req_type` 2) from the owner of an Exclusive block writes its data to memory, leaves the block Uncached with no sharers, and sends no message.
- R9: A write-back from a node that is not the owner of an Exclusive block changes neither memory nor the directory and sends no message.
- R10: From accepting a miss until the cycle after its data reply, `req_ready` is 0. Messages appear only while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | NID_W | Requesting node |
| req_addr | input | AW | Block index within this home |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Fetch response present |
| rsp_src | input | NID_W | Node sending the response |
| rsp_data | input | DATA_W | Block data returned by the owner |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst | output | NID_W | Destination node |
| msg_addr | output | AW | Block index of the message |
| msg_data | output | DATA_W | Reply data (0 for non-reply messages) |

## Verification
The directed part walks one block through every state change in turn. A read from Uncached and a second read from Shared tell simple sharing apart from ownership. Write misses against one sharer and against two sharers show that invalidates reach only recorded nodes and go out in ascending order. A read and a write against an Exclusive block separate the fetch from the fetch-and-invalidate, and a response first sent from the wrong node shows that only the owner releases the wait. Write-backs from a non-owner and then from the owner, each followed by a read, show which one reaches memory. Seeded random traffic over all blocks and nodes then mixes all three request types, so that long sharing histories build up against the bench's own directory model.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2} req_e;
   typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FETCH_INV = 2'd3} msg_e;
   typedef enum logic [1:0] {DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dstate_e;
   typedef enum logic [2:0] {CS_IDLE, CS_INVAL, CS_FETCH, CS_WAIT, CS_REPLY} cstate_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
   parameter int W  = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx
);
   if (W < 2) begin : g_bad_width
      $error("dir_lowbit: W must be at least 2");
   end

   assign onehot = vec & (~vec + W'(1));

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/dir_store.sv
module dir_store
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int BLOCKS = 8,
   parameter int DATA_W = 16,
   localparam int NID_W = $clog2(NODES),
   localparam int AW    = $clog2(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output dstate_e           rd_st,
   output logic [NODES-1:0]  rd_shr,
   output logic [NID_W-1:0]  rd_own,
   output logic [DATA_W-1:0] rd_mem,
   input  logic [AW-1:0]     wr_addr,
   input  logic              dir_we,
   input  dstate_e           dir_st_w,
   input  logic [NODES-1:0]  dir_shr_w,
   input  logic [NID_W-1:0]  dir_own_w,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_wdata
);
   dstate_e           st_q  [BLOCKS];
   logic [NODES-1:0]  shr_q [BLOCKS];
   logic [NID_W-1:0]  own_q [BLOCKS];
   logic [DATA_W-1:0] mem_q [BLOCKS];

   assign rd_st  = st_q[rd_addr];
   assign rd_shr = shr_q[rd_addr];
   assign rd_own = own_q[rd_addr];
   assign rd_mem = mem_q[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BLOCKS; i++) begin
            st_q[i]  <= DS_UNC;
            shr_q[i] <= '0;
            own_q[i] <= '0;
            mem_q[i] <= '0;
         end
      end else begin
         if (dir_we) begin
            st_q[wr_addr]  <= dir_st_w;
            shr_q[wr_addr] <= dir_shr_w;
            own_q[wr_addr] <= dir_own_w;
         end
         if (mem_we) mem_q[wr_addr] <= mem_wdata;
      end
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int BLOCKS = 8,
   parameter int DATA_W = 16,
   localparam int NID_W = $clog2(NODES),
   localparam int AW    = $clog2(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_type,
   input  logic [NID_W-1:0]  req_src,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              rsp_valid,
   input  logic [NID_W-1:0]  rsp_src,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              msg_valid,
   output logic [1:0]        msg_type,
   output logic [NID_W-1:0]  msg_dst,
   output logic [AW-1:0]     msg_addr,
   output logic [DATA_W-1:0] msg_data
);
   if (NODES < 2 || (1 << NID_W) != NODES) begin : g_bad_nodes
      $error("dir_home_ctrl: NODES must be a power of two, at least 2");
   end
   if (BLOCKS < 2 || (1 << AW) != BLOCKS) begin : g_bad_blocks
      $error("dir_home_ctrl: BLOCKS must be a power of two, at least 2");
   end

   cstate_e           cs, cs_n;
   logic              cur_wr;
   logic [NID_W-1:0]  cur_src, cur_own;
   logic [AW-1:0]     cur_addr;
   logic [NODES-1:0]  pend;

   logic [AW-1:0]     rd_addr, wr_addr;
   dstate_e           rd_st, dir_st_w;
   logic [NODES-1:0]  rd_shr, dir_shr_w;
   logic [NID_W-1:0]  rd_own, dir_own_w;
   logic [DATA_W-1:0] rd_mem, mem_wdata;
   logic              dir_we, mem_we;

   logic [NODES-1:0]  pick_oh;
   logic [NID_W-1:0]  pick_idx;

   logic [NODES-1:0]  req_bit, src_bit;
   logic              take_miss, wb_hit, rsp_hit;

   assign req_bit   = NODES'(1) << req_src;
   assign src_bit   = NODES'(1) << cur_src;
   assign req_ready = (cs == CS_IDLE);
   assign take_miss = req_ready && req_valid &&
                      (req_type == REQ_RD || req_type == REQ_WR);
   assign wb_hit    = req_ready && req_valid && req_type == REQ_WB &&
                      rd_st == DS_EXC && rd_own == req_src;
   assign rsp_hit   = (cs == CS_WAIT) && rsp_valid && rsp_src == cur_own;
   assign rd_addr   = req_ready ? req_addr : cur_addr;

   dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr), .rd_st(rd_st), .rd_shr(rd_shr), .rd_own(rd_own), .rd_mem(rd_mem),
      .wr_addr(wr_addr), .dir_we(dir_we), .dir_st_w(dir_st_w), .dir_shr_w(dir_shr_w),
      .dir_own_w(dir_own_w), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   dir_lowbit #(.W(NODES)) u_pick (.vec(pend), .onehot(pick_oh), .idx(pick_idx));

   // Sequencer next state
   always_comb begin
      cs_n = cs;
      unique case (cs)
         CS_IDLE: if (take_miss) begin
            if (rd_st == DS_EXC)
               cs_n = CS_FETCH;
            else if (req_type == REQ_WR && (rd_shr & ~req_bit) != '0)
               cs_n = CS_INVAL;
            else
               cs_n = CS_REPLY;
         end
         CS_INVAL: if ((pend & ~pick_oh) == '0) cs_n = CS_REPLY;
         CS_FETCH: cs_n = CS_WAIT;
         CS_WAIT:  if (rsp_hit) cs_n = CS_REPLY;
         CS_REPLY: cs_n = CS_IDLE;
         default:  cs_n = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs       <= CS_IDLE;
         cur_wr   <= 1'b0;
         cur_src  <= '0;
         cur_own  <= '0;
         cur_addr <= '0;
         pend     <= '0;
      end else begin
         cs <= cs_n;
         if (take_miss) begin
            cur_wr   <= (req_type == REQ_WR);
            cur_src  <= req_src;
            cur_addr <= req_addr;
            cur_own  <= rd_own;
            pend     <= rd_shr & ~req_bit;
         end else if (cs == CS_INVAL) begin
            pend <= pend & ~pick_oh;
         end
      end
   end

   // Directory and memory updates
   always_comb begin
      dir_we    = 1'b0;
      dir_st_w  = DS_UNC;
      dir_shr_w = '0;
      dir_own_w = '0;
      mem_we    = 1'b0;
      mem_wdata = req_data;
      wr_addr   = cur_addr;
      if (wb_hit) begin
         dir_we  = 1'b1;
         mem_we  = 1'b1;
         wr_addr = req_addr;
      end else if (rsp_hit) begin
         mem_we    = 1'b1;
         mem_wdata = rsp_data;
      end else if (cs == CS_REPLY) begin
         dir_we = 1'b1;
         if (cur_wr) begin
            dir_st_w  = DS_EXC;
            dir_shr_w = src_bit;
            dir_own_w = cur_src;
         end else begin
            dir_st_w  = DS_SHR;
            dir_shr_w = rd_shr | src_bit;
            dir_own_w = rd_own;
         end
      end
   end

   // Outgoing message encode
   always_comb begin
      msg_valid = 1'b0;
      msg_type  = MSG_DATA;
      msg_dst   = cur_src;
      msg_data  = '0;
      msg_addr  = cur_addr;
      unique case (cs)
         CS_INVAL: begin
            msg_valid = 1'b1;
            msg_type  = MSG_INV;
            msg_dst   = pick_idx;
         end
         CS_FETCH: begin
            msg_valid = 1'b1;
            msg_type  = cur_wr ? MSG_FETCH_INV : MSG_FETCH;
            msg_dst   = cur_own;
         end
         CS_REPLY: begin
            msg_valid = 1'b1;
            msg_data  = rd_mem;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             msg_valid,
   input logic [1:0]       msg_type,
   input logic [NID_W-1:0] msg_dst,
   input logic [NID_W-1:0] cur_src
);
   a_r10_msgs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);

   a_r10_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'd0) |=> req_ready);

   a_r2_reply_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'd0) |-> msg_dst == cur_src);

   a_r3_inv_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'd1) |-> msg_dst != cur_src);

   a_r3_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'd1 && $past(msg_valid && msg_type == 2'd1))
      |-> msg_dst > $past(msg_dst));

   a_r5_fetch_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type[1]) |=> !msg_valid);
endmodule

bind dir_home_ctrl dir_home_chk #(.NID_W(NID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .msg_valid(msg_valid),
   .msg_type(msg_type), .msg_dst(msg_dst), .cur_src(cur_src)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NN = 4;
   localparam int NB = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_type = '0;
   logic [1:0]    req_src = '0;
   logic [2:0]    req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          rsp_valid = 1'b0;
   logic [1:0]    rsp_src = '0;
   logic [DW-1:0] rsp_data = '0;
   logic          msg_valid;
   logic [1:0]    msg_type;
   logic [1:0]    msg_dst;
   logic [2:0]    msg_addr;
   logic [DW-1:0] msg_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench directory model: 0 Uncached, 1 Shared, 2 Exclusive
   int            m_st  [NB];
   logic [NN-1:0] m_shr [NB];
   int            m_own [NB];
   logic [DW-1:0] m_mem [NB];

   always #(CLK_PERIOD/2) clk = ~clk;

   dir_home_ctrl #(.NODES(NN), .BLOCKS(NB), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_data(rsp_data),
      .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic run_req(input int t, input int s, input int a, input logic [DW-1:0] d, input bit wrong_first);
      logic [NN-1:0] sbit, exp_inv, got_inv;
      bit exp_f, fseen, done;
      int n;
      string tag;
      sbit    = NN'(1) << s;
      exp_f   = (t != 2) && (m_st[a] == 2);
      exp_inv = (t == 1 && m_st[a] != 2) ? (m_shr[a] & ~sbit) : '0;
      if (t == 0) tag = exp_f ? "R5" : "R2";
      else        tag = exp_f ? "R6" : ((exp_inv != 0) ? "R3" : "R4");
      req_valid = 1'b1; req_type = 2'(t); req_src = 2'(s); req_addr = 3'(a); req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (t == 2) begin
         bit hit;
         hit = (m_st[a] == 2 && m_own[a] == s);
         if (hit) begin
            m_mem[a] = d; m_st[a] = 0; m_shr[a] = '0;
         end
         check(!msg_valid && req_ready, hit ? "R8 no message" : "R9 no message",
               {msg_valid, req_ready}, 32'b01);
         return;
      end
      check(!req_ready, "R10 busy after accept", req_ready, 0);
      got_inv = '0; fseen = 0; done = 0; n = 0;
      while (!done && n < 60) begin
         n++;
         if (msg_valid) begin
            if (msg_type == 2'd1) begin
               got_inv |= NN'(1) << msg_dst;
            end else if (msg_type[1]) begin
               int wrong;
               fseen = 1;
               check(msg_dst == 2'(m_own[a]), {tag, " fetch target"}, msg_dst, m_own[a]);
               check(msg_type == ((t == 1) ? 2'd3 : 2'd2), {tag, " fetch kind"}, msg_type, (t == 1) ? 3 : 2);
               @(negedge clk);
               if (wrong_first) begin
                  wrong = (m_own[a] + 1) % NN;
                  rsp_valid = 1'b1; rsp_src = 2'(wrong); rsp_data = ~d;
                  @(negedge clk);
                  @(negedge clk);
                  check(!msg_valid, "R7 foreign response ignored", msg_valid, 0);
               end
               rsp_valid = 1'b1; rsp_src = 2'(m_own[a]); rsp_data = d;
               m_mem[a] = d;
               @(negedge clk);
               rsp_valid = 1'b0;
               continue;
            end else begin
               check(msg_dst == 2'(s), {tag, " reply target"}, msg_dst, s);
               check(msg_addr == 3'(a), {tag, " reply addr"}, msg_addr, a);
               check(msg_data == m_mem[a], {tag, " reply data"}, msg_data, m_mem[a]);
               done = 1;
            end
         end
         if (!done) @(negedge clk);
      end
      check(done, {tag, " reply seen"}, done, 1);
      check(got_inv == exp_inv, "R3 invalidate set", got_inv, exp_inv);
      check(fseen == exp_f, {tag, " fetch issued"}, fseen, exp_f);
      @(negedge clk);
      check(req_ready, "R10 ready after reply", req_ready, 1);
      if (t == 0) begin
         m_st[a] = 1; m_shr[a] = m_shr[a] | sbit;
      end else begin
         m_st[a] = 2; m_shr[a] = sbit; m_own[a] = s;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NB; i++) begin
         m_st[i] = 0; m_shr[i] = '0; m_own[i] = 0; m_mem[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready, "R1 ready", req_ready, 1);
      check(!msg_valid, "R1 no message", msg_valid, 0);
      // directed walk through block 0
      run_req(0, 1, 0, 16'h0, 0);      // R1 zero data, R2 from Uncached
      run_req(0, 2, 0, 16'h0, 0);      // R2 from Shared
      run_req(1, 2, 0, 16'h0, 0);      // R3 invalidate node 1 only
      run_req(0, 3, 0, 16'hA5A5, 1);   // R5 fetch, R7 wrong responder
      run_req(1, 0, 0, 16'h0, 0);      // R3 invalidate 2 then 3
      run_req(1, 1, 0, 16'h3C3C, 0);   // R6 fetch-and-invalidate
      run_req(2, 2, 0, 16'hDEAD, 0);   // R9 non-owner write-back
      run_req(0, 3, 0, 16'h1111, 0);   // owner fetch returns 1111
      run_req(1, 1, 0, 16'h2222, 0);   // R3 back to exclusive at node 1
      m_mem[0] = m_mem[0];
      run_req(0, 1, 0, 16'h0, 0);      // read by owner: fetch from itself
      run_req(1, 1, 0, 16'h0, 0);
      run_req(1, 0, 1, 16'h0, 0);      // R4 Uncached write
      // owner write-back then read
      run_req(1, 1, 0, 16'h7777, 0);
      run_req(2, 1, 0, 16'hBEEF, 0);   // R8
      run_req(0, 0, 0, 16'h0, 0);      // memory holds BEEF, no fetch
      // seeded random traffic
      for (int k = 0; k < 400; k++) begin
         int t, s, a, r;
         r = $urandom_range(0, 9);
         a = $urandom_range(0, NB - 1);
         s = $urandom_range(0, NN - 1);
         t = (r < 4) ? 0 : ((r < 8) ? 1 : 2);
         if (t == 2 && m_st[a] == 2 && $urandom_range(0, 1) == 1) s = m_own[a];
         run_req(t, s, a, DW'($urandom), ($urandom_range(0, 7) == 0));
      end
      finish_run();
   end
endmodule